// File: doc/BRIEF.md
# Power Average and Decimate Unit

This block turns a stream of signed complex samples into a stream of averaged power values. For each accepted sample it forms the power I*I + Q*Q. It scales that value down by a configurable right shift and adds the result into a running partial sum. After every M accepted samples the partial sum closes. The block then emits the sum of the N most recent partial sums. The output is therefore an average over N*M samples, taken once every M samples. The averaging length is always a whole multiple of the decimation ratio, with N from 1 to 4. The shift is a coarse guard against growth. It is normally set to ceil(log2(M*N)), so that the output stays near the scale of a single power sample.

Both sides use valid/ready. An input sample is taken on a clock edge where `in_valid` and `in_ready` are both high. An output word is handed over on an edge where `out_valid` and `out_ready` are both high. While an output is pending and `out_ready` is low, the whole pipeline freezes. During that time `out_data` holds steady and `in_ready` stays low, so no sample is lost or dropped.

The configuration pins are plain levels. Any change on them restarts the averaging: the partial sum in progress and the stored history are discarded.

Top module: `pwr_avg_decim`

## Requirements
- R1: Power is the unsigned sum of the squares of the two's-complement inputs. The extreme input (-32768, -32768) yields exactly 2^31 without wrapping.
- R2: Each power value is shifted right by `cfg_shift` before it is accumulated, and the shift truncates. A field value of 15 acts as 14.
- R3: A partial sum closes after M accepted samples, where M = `cfg_decim` + 1 (1 to 4096).
- R4: Each output is the sum of the N most recent closed partial sums, where N = `cfg_avg_mult` + 1 (1 to 4). Once the history is full, one output is produced per partial sum.
- R5: After reset, or after any change of a configuration pin, the first output comes only after N fresh partial sums. Samples accepted before the change do not contribute.
- R6: `out_valid` rises on the second rising edge after the edge that accepts the sample closing a partial sum. With `out_ready` high it stays up for one clock, unless the next output is due on the next edge.
- R7: While `out_valid` is high and `out_ready` is low, `out_data` and `out_valid` hold and `in_ready` is low. `in_ready` is also low in any cycle where the configuration differs from its value in the previous cycle.
- R8: With full-scale inputs, M = 4096, N = 4 and shift 0, the output is exactly 2^45 and does not overflow.
- R9: Cycles where `in_valid` is low do not count toward M and do not change any sum.
- R10: After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Block can accept a sample |
| in_i | input | 16 | In-phase sample, signed |
| in_q | input | 16 | Quadrature sample, signed |
| cfg_decim | input | 12 | Decimation ratio minus one |
| cfg_avg_mult | input | 2 | Averaging multiple minus one |
| cfg_shift | input | 4 | Right shift before accumulation (15 treated as 14) |
| out_valid | output | 1 | Averaged power valid |
| out_ready | input | 1 | Consumer accepts the output |
| out_data | output | 46 | Averaged power, unsigned |

## Verification
An output is due two edges after the acceptance of the sample that closes a partial sum. The driver records the index of the accepting edge and queues the expected value together with that due edge. The monitor compares both value and edge number whenever an output is handed over, so an early, late or extra output fails. During the back-pressure test the latency comparison is suspended. Instead, the held word and the low `in_ready` are checked over several stalled cycles.

// File: rtl/pwr_avg_pkg.sv
package pwr_avg_pkg;
  localparam int SHIFT_W    = 4;
  localparam int MAX_SHIFT  = 14;
  localparam int MULT_W     = 2;
  localparam int HIST_DEPTH = 1 << MULT_W;

  function automatic logic [SHIFT_W-1:0] clamp_shift(input logic [SHIFT_W-1:0] s);
    return (s > SHIFT_W'(MAX_SHIFT)) ? SHIFT_W'(MAX_SHIFT) : s;
  endfunction
endpackage

// File: rtl/pa_square.sv
module pa_square #(
  parameter int IQ_W  = 16,
  parameter int PWR_W = 2 * IQ_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    adv,
  input  logic                    flush,
  input  logic                    fire,
  input  logic signed [IQ_W-1:0]  smp_i,
  input  logic signed [IQ_W-1:0]  smp_q,
  output logic                    pwr_v,
  output logic [PWR_W-1:0]        pwr_q
);
  logic signed [PWR_W-1:0] sq_i, sq_q;
  logic [PWR_W-1:0]        pwr_d;

  always_comb begin
    sq_i  = PWR_W'(smp_i) * PWR_W'(smp_i);
    sq_q  = PWR_W'(smp_q) * PWR_W'(smp_q);
    pwr_d = $unsigned(sq_i) + $unsigned(sq_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr_v <= 1'b0;
      pwr_q <= '0;
    end else if (flush) begin
      pwr_v <= 1'b0;
    end else if (adv) begin
      pwr_v <= fire;
      if (fire) pwr_q <= pwr_d;
    end
  end

  // R1: power never exceeds 2^(PWR_W-1)
  a_r1_power_max: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_v && pwr_q[PWR_W-1]) |-> (pwr_q[PWR_W-2:0] == '0));
endmodule

// File: rtl/pa_accum.sv
module pa_accum
  import pwr_avg_pkg::*;
#(
  parameter int PWR_W = 32,
  parameter int M_W   = 12,
  parameter int PS_W  = PWR_W + M_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               adv,
  input  logic               flush,
  input  logic               pwr_v,
  input  logic [PWR_W-1:0]   pwr_q,
  input  logic [SHIFT_W-1:0] shift,
  input  logic [M_W-1:0]     m_last,
  output logic               ps_v,
  output logic [PS_W-1:0]    ps_q
);
  logic [M_W-1:0]   cnt;
  logic [PS_W-1:0]  acc, acc_nx;
  logic [PWR_W-1:0] scaled;
  logic             closing;

  always_comb begin
    scaled  = pwr_q >> clamp_shift(shift);
    acc_nx  = acc + {{M_W{1'b0}}, scaled};
    closing = pwr_v && (cnt == m_last);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      acc  <= '0;
      ps_v <= 1'b0;
      ps_q <= '0;
    end else if (flush) begin
      cnt  <= '0;
      acc  <= '0;
      ps_v <= 1'b0;
    end else if (adv) begin
      ps_v <= closing;
      if (closing) begin
        ps_q <= acc_nx;
        acc  <= '0;
        cnt  <= '0;
      end else if (pwr_v) begin
        acc <= acc_nx;
        cnt <= cnt + M_W'(1);
      end
    end
  end

  // R3: the sample counter stays inside the decimation window
  a_r3_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    !flush |=> (cnt <= m_last) || (m_last != $past(m_last)));

  // R8: the running sum grows without wrapping until it closes
  a_r8_acc_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !flush && pwr_v && !closing) |=> (acc >= $past(acc)));
endmodule

// File: rtl/pa_history.sv
module pa_history
  import pwr_avg_pkg::*;
#(
  parameter int PS_W  = 44,
  parameter int OUT_W = PS_W + MULT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic              flush,
  input  logic              ps_v,
  input  logic [PS_W-1:0]   ps_q,
  input  logic [MULT_W-1:0] n_m1,
  output logic              sum_v,
  output logic [OUT_W-1:0]  sum_q
);
  localparam int FILL_W = $clog2(HIST_DEPTH + 1);

  logic [PS_W-1:0]   hist [HIST_DEPTH-1];
  logic [OUT_W-1:0]  term [HIST_DEPTH];
  logic [OUT_W-1:0]  total;
  logic [FILL_W-1:0] fill;
  logic              enough;

  assign term[0] = OUT_W'(ps_q);

  genvar g;
  generate
    for (g = 0; g < HIST_DEPTH - 1; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hist[g] <= '0;
        else if (adv && ps_v && !flush) begin
          if (g == 0) hist[g] <= ps_q;
          else        hist[g] <= hist[(g > 0) ? g - 1 : 0];
        end
      end
      assign term[g+1] = (MULT_W'(g + 1) <= n_m1) ? OUT_W'(hist[g]) : '0;
    end
  endgenerate

  always_comb begin
    total = '0;
    for (int k = 0; k < HIST_DEPTH; k++) total = total + term[k];
    enough = (FILL_W'(n_m1) <= fill);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill  <= '0;
      sum_v <= 1'b0;
      sum_q <= '0;
    end else if (flush) begin
      fill  <= '0;
      sum_v <= 1'b0;
    end else if (adv) begin
      sum_v <= ps_v && enough;
      if (ps_v) begin
        if (fill < FILL_W'(HIST_DEPTH)) fill <= fill + FILL_W'(1);
        if (enough) sum_q <= total;
      end
    end
  end

  // R5: the history count never exceeds its depth
  a_r5_fill_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= FILL_W'(HIST_DEPTH));
endmodule

// File: rtl/pwr_avg_decim.sv
module pwr_avg_decim
  import pwr_avg_pkg::*;
#(
  parameter int IQ_W = 16,
  parameter int M_W  = 12,
  localparam int PWR_W = 2 * IQ_W,
  localparam int PS_W  = PWR_W + M_W,
  localparam int OUT_W = PS_W + MULT_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic signed [IQ_W-1:0] in_i,
  input  logic signed [IQ_W-1:0] in_q,
  input  logic [M_W-1:0]         cfg_decim,
  input  logic [MULT_W-1:0]      cfg_avg_mult,
  input  logic [SHIFT_W-1:0]     cfg_shift,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [OUT_W-1:0]       out_data
);
  localparam int CFG_W = M_W + MULT_W + SHIFT_W;

  logic [CFG_W-1:0] cfg_now, cfg_seen;
  logic             flush, adv, fire;
  logic             pwr_v, ps_v;
  logic [PWR_W-1:0] pwr_q;
  logic [PS_W-1:0]  ps_q;

  assign cfg_now  = {cfg_decim, cfg_avg_mult, cfg_shift};
  assign flush    = (cfg_now != cfg_seen);
  assign adv      = !(out_valid && !out_ready);
  assign in_ready = adv && !flush;
  assign fire     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_seen <= '0;
    else        cfg_seen <= cfg_now;
  end

  pa_square #(.IQ_W(IQ_W), .PWR_W(PWR_W)) u_sq (
    .clk(clk), .rst_n(rst_n), .adv(adv), .flush(flush), .fire(fire),
    .smp_i(in_i), .smp_q(in_q), .pwr_v(pwr_v), .pwr_q(pwr_q));

  pa_accum #(.PWR_W(PWR_W), .M_W(M_W), .PS_W(PS_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .adv(adv), .flush(flush),
    .pwr_v(pwr_v), .pwr_q(pwr_q), .shift(cfg_shift), .m_last(cfg_decim),
    .ps_v(ps_v), .ps_q(ps_q));

  pa_history #(.PS_W(PS_W), .OUT_W(OUT_W)) u_hist (
    .clk(clk), .rst_n(rst_n), .adv(adv), .flush(flush),
    .ps_v(ps_v), .ps_q(ps_q), .n_m1(cfg_avg_mult),
    .sum_v(out_valid), .sum_q(out_data));

  // R7: a refused output word is held unchanged
  a_r7_hold_output: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !flush) |=> (out_valid && $stable(out_data)));

  // R9: without an accepted sample the power stage reports nothing new
  a_r9_no_phantom: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !fire) |=> !pwr_v);
endmodule

// File: tb/sim_pwr_avg_decim.sv
module sim_pwr_avg_decim;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b1;
  logic signed [15:0] in_i = '0, in_q = '0;
  logic [11:0] cfg_decim = '0;
  logic [1:0]  cfg_avg_mult = '0;
  logic [3:0]  cfg_shift = '0;
  logic        in_ready, out_valid;
  logic [45:0] out_data;

  always #5 clk = ~clk;

  pwr_avg_decim u0 (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_i(in_i), .in_q(in_q), .cfg_decim(cfg_decim), .cfg_avg_mult(cfg_avg_mult),
    .cfg_shift(cfg_shift), .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data));

  int cyc = 0, checks = 0, errors = 0;
  bit lat_chk = 1'b1;
  longint exp_q[$];
  int     due_q[$];
  string  tag_q[$];
  longint m_acc, m_hist[4];
  int     m_cnt, m_fill;
  string  cur_tag = "R3";

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(string req, longint act, longint expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic model_reset();
    m_acc = 0; m_cnt = 0; m_fill = 0;
    for (int k = 0; k < 4; k++) m_hist[k] = 0;
  endtask

  task automatic model(longint i, longint q, int edge_no);
    longint p, s, tot;
    int sh;
    p  = i * i + q * q;
    sh = (cfg_shift > 4'd14) ? 14 : int'(cfg_shift);
    s  = p >> sh;
    m_acc += s;
    m_cnt++;
    if (m_cnt == int'(cfg_decim) + 1) begin
      for (int k = 3; k > 0; k--) m_hist[k] = m_hist[k-1];
      m_hist[0] = m_acc;
      m_acc = 0; m_cnt = 0;
      if (m_fill < 4) m_fill++;
      if (m_fill >= int'(cfg_avg_mult) + 1) begin
        tot = 0;
        for (int k = 0; k <= int'(cfg_avg_mult); k++) tot += m_hist[k];
        exp_q.push_back(tot); due_q.push_back(edge_no + 2); tag_q.push_back(cur_tag);
      end
    end
  endtask

  task automatic send(longint i, longint q);
    int a;
    @(negedge clk);
    in_i = 16'(i); in_q = 16'(q); in_valid = 1'b1;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    a = cyc + 1;
    model(i, q, a);
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_cfg(int m_m1, int n_m1, int s);
    idle(4);
    @(negedge clk);
    cfg_decim = 12'(m_m1); cfg_avg_mult = 2'(n_m1); cfg_shift = 4'(s);
    model_reset();
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    #1;
    if (rst_n && out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        check("R6 unexpected output", longint'(out_data), -1);
      end else begin
        string t;
        longint e;
        int d;
        e = exp_q.pop_front(); d = due_q.pop_front(); t = tag_q.pop_front();
        check(t, longint'(out_data), e);
        if (lat_chk) check("R6 latency", cyc, d);
      end
    end
  end

  initial begin
    fork
      begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    join_none

    model_reset();
    idle(2);
    #1;
    check("R10 out_valid", longint'(out_valid), 0);
    rst_n = 1'b1;
    #1;
    check("R10 in_ready", longint'(in_ready), 1);

    // M=1 N=1 S=0, back-to-back, R1 extremes
    set_cfg(0, 0, 0);
    cur_tag = "R1";
    send(3, 4); send(-32768, -32768); send(0, -5); send(32767, -32768); send(-1, 1);
    idle(6);

    // R2 truncation and R3 window: M=4 S=2
    set_cfg(3, 0, 2);
    cur_tag = "R2";
    send(1, 1); send(1, 2); send(2, 2); send(3, 0);
    cur_tag = "R3";
    send(7, -9); send(100, 3); send(-1, 0); send(5, 5);
    idle(6);

    // R2 field value 15 acts as 14
    set_cfg(0, 0, 15);
    cur_tag = "R2";
    send(-32768, -32768); send(100, 0); send(300, 400);
    idle(6);

    // R4 R5 R9: M=3 N=3 with gaps
    set_cfg(2, 2, 0);
    cur_tag = "R4";
    for (int k = 0; k < 15; k++) begin
      send(k * 37 - 200, 11 - k * 5);
      if (k % 3 == 1) idle(k % 4 + 1);
    end
    idle(6);
    check("R5 nothing pending", exp_q.size(), 0);

    // R5 config change discards partial work
    set_cfg(1, 1, 0);
    cur_tag = "R5";
    send(10, 0); send(20, 0); send(30, 0);
    set_cfg(1, 0, 0);
    send(1, 2); send(3, 4);
    idle(6);

    // R7 back-pressure
    set_cfg(0, 0, 0);
    cur_tag = "R7";
    @(negedge clk); out_ready = 1'b0; lat_chk = 1'b0;
    send(12, 5);
    idle(3);
    for (int k = 0; k < 3; k++) begin
      #1;
      check("R7 valid held", longint'(out_valid), 1);
      check("R7 data held", longint'(out_data), 169);
      check("R7 in_ready low", longint'(in_ready), 0);
      @(negedge clk);
    end
    out_ready = 1'b1;
    idle(4);
    lat_chk = 1'b1;
    send(6, 8);
    idle(6);

    // R8 full scale, M=4096 N=4
    set_cfg(4095, 3, 0);
    cur_tag = "R8";
    for (int k = 0; k < 16384; k++) send(-32768, -32768);
    idle(8);
    check("R8 drained", exp_q.size(), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule